// File: doc/BRIEF.md
# OTP Byte Programming Sequencer

This block burns a contiguous range of bytes into a one-time-programmable cell array and then confirms the result. It drives an abstract cell port: an address, the write byte, a read-back byte, a program strobe and a flag that asks for the high programming voltage. The byte to burn at each address comes from a data source port. The source is addressed by `src_addr` and answers combinationally on `src_data`.

A run starts with `start` while the mode lines select the program operation. Each byte gets a timed program strobe at high voltage and then a one-cycle verify read. A byte whose verify keeps failing is given a bounded number of attempts. When every byte has verified, the block lowers the voltage flag for one cycle. It then reads back the whole range at normal voltage and compares it against the source. The run ends with `pass` or `fail`. The block also decodes the mode lines into an operation code on `mode_op`.

States: IDLE (waiting), PULSE (strobe high for the pulse width), CHECK (verify read at high voltage), SETTLE (voltage lowered), SWEEP (final comparison). Transitions:
- IDLE to PULSE on an accepted start with a valid range.
- IDLE to IDLE with `fail` on an accepted start with an inverted range.
- PULSE to CHECK when the pulse timer ends.
- CHECK to PULSE on a mismatch with attempts left, or on a match that is not the last byte.
- CHECK to SETTLE on a match of the last byte.
- CHECK to IDLE with `fail` when the attempts are used up.
- SETTLE to SWEEP always.
- SWEEP to IDLE with `fail` on a mismatch, or with `pass` after the last byte.

Top module: `otp_prog_seq`

## Requirements
- R1: `mode_op` decodes the mode lines as follows. Normal voltage (`vpp_high`=0) with `reg_sel`=0 and `rw_n`=1 gives READ=1. High voltage with `reg_sel`=0 gives PROGRAM=2 when `rw_n`=0 and VERIFY=3 when `rw_n`=1. High voltage with `reg_sel`=1, `rw_n`=0 and `first_addr`=12'hE3F gives PROTECT=4. Every other combination gives NONE=0.
- R2: `start` is accepted only in IDLE while `mode_op` is PROGRAM. Any other start leaves `busy`, `pass`, `fail` and the cell strobe unchanged.
- R3: An accepted start with `first_addr` > `last_addr` sets `fail` at that same clock edge. No strobe is issued and `busy` stays low.
- R4: Each attempt holds `cell_pulse` and `cell_hv` high for PULSE_CYC = CLK_KHZ*PULSE_US/1000 cycles. One verify cycle at high voltage follows, so an attempt takes PULSE_CYC+1 cycles.
- R5: A verify match advances to the next address with a fresh attempt count. A match at the last address leads to the final comparison.
- R6: The block fails at the verify where a byte misses for the MAX_TRY-th time (default 10). A byte that matches on attempt MAX_TRY still passes.
- R7: After programming, one cycle with `cell_hv` low is followed by one compare per byte. If every byte matches, `pass` is set. From start to result this takes (total attempts)*(PULSE_CYC+1) + 1 + (byte count) cycles.
- R8: A mismatch at byte index j of the final comparison sets `fail` j+1 cycles after the settle cycle.
- R9: `busy` is high from an accepted start until the result. `pass` and `fail` are never both high, and each holds until the next accepted start.
- R10: A `start` during a run is ignored, including any new addresses on the ports. The run's result and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request |
| first_addr | input | AW | First byte address (also checked by the protect decode) |
| last_addr | input | AW | Last byte address |
| vpp_high | input | 1 | Programming supply at its high level |
| reg_sel | input | 1 | Register/memory select mode line |
| rw_n | input | 1 | Read (1) / write (0) mode line |
| src_data | input | DW | Byte from the data source at `src_addr` |
| src_addr | output | AW | Address presented to the data source |
| cell_addr | output | AW | Cell array address |
| cell_wdata | output | DW | Byte to burn |
| cell_rdata | input | DW | Byte read from the cell array |
| cell_pulse | output | 1 | Program strobe |
| cell_hv | output | 1 | High-voltage request |
| mode_op | output | 3 | Decoded operation code |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Device passed |
| fail | output | 1 | Device failed |

## Verification
The decode on `mode_op` is combinational and is sampled a moment after the mode lines change. Every run result is registered. It is due a fixed number of edges after the edge that samples `start`: zero for an inverted range, and otherwise the count in R7 or R8, or the attempt sum up to the exhausting verify from R6. The monitor counts falling edges from the start edge and compares that count with the value pushed into the scoreboard. It also counts strobe cycles per run, which must equal attempts times PULSE_CYC. Ignored starts are judged on the outputs a few cycles later, before any other stimulus.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_READ    = 3'd1,
        OP_PROG    = 3'd2,
        OP_VERIFY  = 3'd3,
        OP_PROTECT = 3'd4
    } op_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PULSE,
        S_CHECK,
        S_SETTLE,
        S_SWEEP
    } st_t;
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_seq_pkg::*;
#(
    parameter int          AW        = 12,
    parameter logic [AW-1:0] PROT_ADDR = 12'hE3F
) (
    input  logic          vpp_high,
    input  logic          reg_sel,
    input  logic          rw_n,
    input  logic [AW-1:0] addr,
    output op_t           op
);
    always_comb begin
        op = OP_NONE;
        if (!vpp_high) begin
            if (rw_n && !reg_sel) op = OP_READ;
        end else if (!reg_sel) begin
            op = rw_n ? OP_VERIFY : OP_PROG;
        end else if (!rw_n && addr == PROT_ADDR) begin
            op = OP_PROTECT;
        end
    end
endmodule

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
    parameter int CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (!run) cnt <= '0;
        else          cnt <= cnt + CW'(1);
    end

    assign last = run && (cnt == CW'(CYC - 1));

    // R4: the strobe never outlasts the pulse width
    p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < CW'(CYC)));
endmodule

// File: rtl/otp_try_counter.sv
module otp_try_counter #(
    parameter int MAX = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic spent
);
    localparam int TW = $clog2(MAX + 1);

    logic [TW-1:0] tries;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     tries <= '0;
        else if (clear) tries <= '0;
        else if (bump)  tries <= tries + TW'(1);
    end

    assign spent = (tries == TW'(MAX - 1));

    // R6: failed attempts never reach the limit without ending the run
    p_try_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tries < TW'(MAX));
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int            AW        = 12,
    parameter int            DW        = 8,
    parameter int            CLK_KHZ   = 100000,
    parameter int            PULSE_US  = 1000,
    parameter int            MAX_TRY   = 10,
    parameter logic [AW-1:0] PROT_ADDR = 12'hE3F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    input  logic          vpp_high,
    input  logic          reg_sel,
    input  logic          rw_n,
    input  logic [DW-1:0] src_data,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] cell_addr,
    output logic [DW-1:0] cell_wdata,
    input  logic [DW-1:0] cell_rdata,
    output logic          cell_pulse,
    output logic          cell_hv,
    output logic [2:0]    mode_op,
    output logic          busy,
    output logic          pass,
    output logic          fail
);
    localparam int PULSE_CYC = (CLK_KHZ * PULSE_US) / 1000;

    st_t           state, nxt;
    op_t           op;
    logic [AW-1:0] addr, nxt_addr, lo_q, hi_q;
    logic          start_ok, pulse_last, spent;
    logic          try_clear, try_bump, set_pass, set_fail;

    otp_mode_decode #(.AW(AW), .PROT_ADDR(PROT_ADDR)) u_dec (
        .vpp_high(vpp_high), .reg_sel(reg_sel), .rw_n(rw_n),
        .addr(first_addr), .op(op)
    );

    otp_pulse_timer #(.CYC(PULSE_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(state == S_PULSE), .last(pulse_last)
    );

    otp_try_counter #(.MAX(MAX_TRY)) u_try (
        .clk(clk), .rst_n(rst_n), .clear(try_clear), .bump(try_bump),
        .spent(spent)
    );

    assign start_ok = start && (state == S_IDLE) && (op == OP_PROG);

    always_comb begin
        nxt       = state;
        nxt_addr  = addr;
        try_clear = 1'b0;
        try_bump  = 1'b0;
        set_pass  = 1'b0;
        set_fail  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start_ok) begin
                    if (first_addr > last_addr) begin
                        set_fail = 1'b1;
                    end else begin
                        nxt       = S_PULSE;
                        nxt_addr  = first_addr;
                        try_clear = 1'b1;
                    end
                end
            end
            S_PULSE: begin
                if (pulse_last) nxt = S_CHECK;
            end
            S_CHECK: begin
                if (cell_rdata == src_data) begin
                    try_clear = 1'b1;
                    if (addr == hi_q) begin
                        nxt = S_SETTLE;
                    end else begin
                        nxt_addr = addr + AW'(1);
                        nxt      = S_PULSE;
                    end
                end else if (spent) begin
                    set_fail = 1'b1;
                    nxt      = S_IDLE;
                end else begin
                    try_bump = 1'b1;
                    nxt      = S_PULSE;
                end
            end
            S_SETTLE: begin
                nxt      = S_SWEEP;
                nxt_addr = lo_q;
            end
            S_SWEEP: begin
                if (cell_rdata != src_data) begin
                    set_fail = 1'b1;
                    nxt      = S_IDLE;
                end else if (addr == hi_q) begin
                    set_pass = 1'b1;
                    nxt      = S_IDLE;
                end else begin
                    nxt_addr = addr + AW'(1);
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            addr  <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            pass  <= 1'b0;
            fail  <= 1'b0;
        end else begin
            state <= nxt;
            addr  <= nxt_addr;
            if (start_ok) begin
                lo_q <= first_addr;
                hi_q <= last_addr;
                pass <= 1'b0;
                fail <= 1'b0;
            end
            if (set_pass) pass <= 1'b1;
            if (set_fail) fail <= 1'b1;
        end
    end

    always_comb begin
        busy       = (state != S_IDLE);
        cell_hv    = (state == S_PULSE) || (state == S_CHECK);
        cell_pulse = (state == S_PULSE);
        cell_addr  = addr;
        src_addr   = addr;
        cell_wdata = src_data;
        mode_op    = op;
    end

    // R9: results exclusive, quiet while busy, held, and a run always ends in one
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));
    p_quiet_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!pass && !fail));
    p_hold_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass && !start) |=> pass);
    p_hold_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);
    p_end_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (pass || fail));
    // R3: an inverted range fails at once
    p_bad_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode_op == 3'd2 && first_addr > last_addr)
        |=> (fail && !busy));
endmodule

// File: tb/otp_prog_seq_tb.sv
module otp_prog_seq_tb;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam int P  = 4;
    localparam int MT = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] first_addr = '0, last_addr = '0;
    logic          vpp_high = 1'b1, reg_sel = 1'b0, rw_n = 1'b0;
    logic [DW-1:0] src_data, cell_wdata, cell_rdata;
    logic [AW-1:0] src_addr, cell_addr;
    logic          cell_pulse, cell_hv, busy, pass, fail;
    logic [2:0]    mode_op;

    always #5 clk = ~clk;

    otp_prog_seq #(.AW(AW), .DW(DW), .CLK_KHZ(4000), .PULSE_US(1),
                   .MAX_TRY(MT), .PROT_ADDR(12'hE3F)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
        .last_addr(last_addr), .vpp_high(vpp_high), .reg_sel(reg_sel),
        .rw_n(rw_n), .src_data(src_data), .src_addr(src_addr),
        .cell_addr(cell_addr), .cell_wdata(cell_wdata),
        .cell_rdata(cell_rdata), .cell_pulse(cell_pulse), .cell_hv(cell_hv),
        .mode_op(mode_op), .busy(busy), .pass(pass), .fail(fail)
    );

    // data source and cell array model
    logic [DW-1:0] mem  [0:4095];
    int            need [0:4095];
    int            hits [0:4095];
    int            corrupt = -1;
    logic          prev_pulse = 1'b0, prev_hv = 1'b0;

    assign src_data   = src_addr[7:0] ^ 8'hA5;
    assign cell_rdata = mem[cell_addr];

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i] = '0; need[i] = 1; hits[i] = 0;
        end
    end

    always @(posedge clk) begin
        if (cell_pulse && !prev_pulse && cell_hv) begin
            hits[cell_addr] = hits[cell_addr] + 1;
            if (hits[cell_addr] >= need[cell_addr]) mem[cell_addr] = cell_wdata;
        end
        if (prev_hv && !cell_hv && corrupt >= 0)
            mem[corrupt] = mem[corrupt] ^ 8'h01;
        prev_pulse = cell_pulse;
        prev_hv    = cell_hv;
    end

    // scoreboard
    typedef struct { bit ok; int cyc; int pulses; string tag; } exp_t;
    exp_t exp_q[$];
    int   n_chk = 0, n_bad = 0;
    bit   armed = 1'b0;
    int   ncyc = 0, npul = 0;

    task automatic chk(input bit c, input string tag, input int act, input int expv);
        n_chk++;
        if (!c) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            if (cell_pulse) npul++;
            if (pass || fail) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(pass == e.ok && fail == !e.ok, {e.tag, " result"}, int'(pass), int'(e.ok));
                chk(ncyc == e.cyc, {e.tag, " cycles"}, ncyc, e.cyc);
                chk(npul == e.pulses, {e.tag, " strobe cycles"}, npul, e.pulses);
                armed = 1'b0;
            end else begin
                ncyc++;
            end
        end
    end

    task automatic run_case(input int lo, input int hi, input bit ok, input int cyc,
                            input int pulses, input string tag, input int inject);
        exp_t e;
        e.ok = ok; e.cyc = cyc; e.pulses = pulses; e.tag = tag;
        exp_q.push_back(e);
        first_addr = AW'(lo); last_addr = AW'(hi);
        @(negedge clk); start = 1'b1;
        @(posedge clk); #1; start = 1'b0; ncyc = 0; npul = 0; armed = 1'b1;
        if (inject > 0) begin
            repeat (inject) @(negedge clk);
            first_addr = 12'h001; last_addr = 12'h002; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        wait (!armed);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !pass && !fail, "reset R9", int'({busy, pass, fail}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 decode
        vpp_high = 0; reg_sel = 0; rw_n = 1; #1 chk(mode_op == 3'd1, "R1 read", mode_op, 1);
        vpp_high = 0; reg_sel = 0; rw_n = 0; #1 chk(mode_op == 3'd0, "R1 none low", mode_op, 0);
        vpp_high = 1; reg_sel = 0; rw_n = 1; #1 chk(mode_op == 3'd3, "R1 verify", mode_op, 3);
        vpp_high = 1; reg_sel = 1; rw_n = 0; first_addr = 12'hE3F;
        #1 chk(mode_op == 3'd4, "R1 protect", mode_op, 4);
        first_addr = 12'hE3E; #1 chk(mode_op == 3'd0, "R1 protect addr", mode_op, 0);
        vpp_high = 1; reg_sel = 0; rw_n = 0; #1 chk(mode_op == 3'd2, "R1 program", mode_op, 2);
        @(negedge clk);

        // R4 R5 R7 plain pass: 4 bytes, 1 attempt each
        run_case(12'h010, 12'h013, 1, 4*(P+1)+1+4, 4*P, "R7 pass", 0);
        // R6 retries: 3,1,10 attempts, still passes
        need[12'h020] = 3; need[12'h022] = 10;
        run_case(12'h020, 12'h022, 1, 14*(P+1)+1+3, 14*P, "R6 retry pass", 0);
        // R6 exhausted at byte 1 after byte 0 took 2
        need[12'h030] = 2; need[12'h031] = 11;
        run_case(12'h030, 12'h032, 0, 12*(P+1), 12*P, "R6 exhausted", 0);
        // R8 compare mismatch at index 2
        corrupt = 12'h042;
        run_case(12'h040, 12'h043, 0, 4*(P+1)+1+3, 4*P, "R8 sweep mismatch", 0);
        corrupt = -1;
        // R5 single byte
        run_case(12'h050, 12'h050, 1, (P+1)+1+1, P, "R5 single", 0);
        // R3 inverted range
        run_case(12'h070, 12'h060, 0, 0, 0, "R3 inverted", 0);

        // R2 start ignored at normal voltage: fail from the last run must hold
        vpp_high = 0; rw_n = 1; first_addr = 12'h080; last_addr = 12'h081;
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy && fail && !pass && !cell_pulse, "R2 ignored start",
            int'({busy, pass, fail, cell_pulse}), 2);
        vpp_high = 1; rw_n = 0;

        // R10 start during a run
        run_case(12'h090, 12'h091, 1, 2*(P+1)+1+2, 2*P, "R10 busy start", 3);
        chk(mem[12'h001] == 8'h00, "R10 no stray write", mem[12'h001], 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule